// File: doc/BRIEF.md
# Animated Raster Test Pattern Source

This block runs in the pixel clock domain and produces the scan timing and pixel colours of a self-animating test image. A horizontal counter and a vertical counter sweep a total frame that is larger than the visible picture. The spare columns and rows leave room for blanking and sync, which a downstream stage places. The block presents the current coordinate and a flag that marks the visible region.

Each visible pixel gets a 24-bit colour that is a fixed function of its coordinate and of an 8-bit frame count. Because the frame count moves once per frame, the image drifts from one frame to the next. Outside the visible region the colour is black.

Visible size, total size and coordinate widths are parameters. A parameter set is rejected at elaboration if any of these hold:
- the total frame is less than 30 columns wider than the visible width;
- the total frame is less than 15 rows taller than the visible height;
- a coordinate does not fit its output width.

The defaults are a 1280x720 picture inside a 1667x750 frame.

Top module: `tpg_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, x, y and the frame count become 0. A reset wins over a frame advance in the same cycle.
- R2: In every cycle out of reset, x rises by one. After the value H_TOT-1 it returns to 0.
- R3: y changes only in the cycle after x equals H_TOT-1. There it rises by one, or returns to 0 if it was V_TOT-1.
- R4: `active` is 1 exactly when x < H_VIS and y < V_VIS.
- R5: While active, `red` = (x mod 256 + frame) mod 256.
- R6: While active, `green` = (y mod 256 + 2*frame) mod 256.
- R7: While active, `blue` = (x mod 256) XOR (y mod 256).
- R8: While `active` is 0, `red`, `green` and `blue` are all 0.
- R9: The 8-bit frame count rises by one after the cycle in which active is 1, x = H_VIS-1 and y = V_VIS-1. It holds in every other cycle, and it wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| x | output | X_BITS (11) | Current column |
| y | output | Y_BITS (10) | Current row |
| active | output | 1 | Current pixel lies in the visible region |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel |

## Verification
The frame count advance and a synchronous reset can fall in the same cycle. Both act on the frame count register in that cycle, and the reset must win. The bench waits until its own reference model stands on the last visible pixel of a frame whose count is not zero, then raises reset for that single edge. On the next visible pixel it expects a count of 0, seen through `red` at column 0, rather than the advanced value. Random reset pulses during free running also land on other phases of the scan, and a long run without reset carries the count through its wrap from 255 to 0.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int CHAN_BITS = 8;

    typedef logic [CHAN_BITS-1:0] chan_t;

    typedef struct packed {
        chan_t r;
        chan_t g;
        chan_t b;
    } rgb_t;

    // Colour of a visible pixel from the low coordinate bits and frame count.
    function automatic rgb_t shade_of(input chan_t col, input chan_t row, input chan_t frm);
        rgb_t c;
        c.r = col + frm;
        c.g = row + {frm[CHAN_BITS-2:0], 1'b0};
        c.b = col ^ row;
        return c;
    endfunction

endpackage

// File: rtl/tpg_raster.sv
module tpg_raster #(
    parameter int H_VIS  = 1280,
    parameter int H_TOT  = 1667,
    parameter int V_VIS  = 720,
    parameter int V_TOT  = 750,
    parameter int X_BITS = 11,
    parameter int Y_BITS = 10
) (
    input  logic              clk,
    input  logic              rst,
    output logic [X_BITS-1:0] x,
    output logic [Y_BITS-1:0] y,
    output logic              active,
    output logic              last_vis
);
    localparam logic [X_BITS-1:0] X_LAST     = X_BITS'(H_TOT - 1);
    localparam logic [Y_BITS-1:0] Y_LAST     = Y_BITS'(V_TOT - 1);
    localparam logic [X_BITS-1:0] X_VIS_END  = X_BITS'(H_VIS);
    localparam logic [Y_BITS-1:0] Y_VIS_END  = Y_BITS'(V_VIS);
    localparam logic [X_BITS-1:0] X_VIS_LAST = X_BITS'(H_VIS - 1);
    localparam logic [Y_BITS-1:0] Y_VIS_LAST = Y_BITS'(V_VIS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            x <= '0;
            y <= '0;
        end else if (x == X_LAST) begin
            x <= '0;
            y <= (y == Y_LAST) ? '0 : y + 1'b1;
        end else begin
            x <= x + 1'b1;
        end
    end

    always_comb begin
        active   = (x < X_VIS_END) && (y < Y_VIS_END);
        last_vis = active && (x == X_VIS_LAST) && (y == Y_VIS_LAST);
    end
endmodule

// File: rtl/tpg_frame_ctr.sv
module tpg_frame_ctr
    import tpg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    output chan_t frame
);
    always_ff @(posedge clk) begin
        if (rst)
            frame <= '0;
        else if (advance)
            frame <= frame + 1'b1;
    end
endmodule

// File: rtl/tpg_shade.sv
module tpg_shade
    import tpg_pkg::*;
#(
    parameter int X_BITS = 11,
    parameter int Y_BITS = 10
) (
    input  logic [X_BITS-1:0] x,
    input  logic [Y_BITS-1:0] y,
    input  logic              active,
    input  chan_t             frame,
    output rgb_t              pix
);
    always_comb begin
        if (active)
            pix = shade_of(x[CHAN_BITS-1:0], y[CHAN_BITS-1:0], frame);
        else
            pix = '0;
    end
endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
#(
    parameter int H_VIS  = 1280,
    parameter int H_TOT  = 1667,
    parameter int V_VIS  = 720,
    parameter int V_TOT  = 750,
    parameter int X_BITS = 11,
    parameter int Y_BITS = 10
) (
    input  logic              clk,
    input  logic              rst,
    output logic [X_BITS-1:0] x,
    output logic [Y_BITS-1:0] y,
    output logic              active,
    output logic [7:0]        red,
    output logic [7:0]        green,
    output logic [7:0]        blue
);
    localparam int H_PAD_MIN = 30;
    localparam int V_PAD_MIN = 15;

    if (H_VIS < 1 || V_VIS < 1) begin : g_bad_vis
        $error("tpg_top: visible size must be positive");
    end
    if (H_TOT < H_VIS + H_PAD_MIN) begin : g_bad_hpad
        $error("tpg_top: total width needs at least %0d spare columns", H_PAD_MIN);
    end
    if (V_TOT < V_VIS + V_PAD_MIN) begin : g_bad_vpad
        $error("tpg_top: total height needs at least %0d spare rows", V_PAD_MIN);
    end
    if (X_BITS < CHAN_BITS || Y_BITS < CHAN_BITS) begin : g_bad_width
        $error("tpg_top: coordinate widths must be at least %0d", CHAN_BITS);
    end
    if (H_TOT > (1 << X_BITS) || V_TOT > (1 << Y_BITS)) begin : g_bad_fit
        $error("tpg_top: total frame does not fit coordinate widths");
    end

    logic  last_vis;
    chan_t frame_q;
    rgb_t  pix;

    tpg_raster #(
        .H_VIS(H_VIS), .H_TOT(H_TOT), .V_VIS(V_VIS), .V_TOT(V_TOT),
        .X_BITS(X_BITS), .Y_BITS(Y_BITS)
    ) u_raster (
        .clk(clk), .rst(rst), .x(x), .y(y), .active(active), .last_vis(last_vis)
    );

    tpg_frame_ctr u_frame (
        .clk(clk), .rst(rst), .advance(last_vis), .frame(frame_q)
    );

    tpg_shade #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_shade (
        .x(x), .y(y), .active(active), .frame(frame_q), .pix(pix)
    );

    assign red   = pix.r;
    assign green = pix.g;
    assign blue  = pix.b;
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker #(
    parameter int H_VIS  = 1280,
    parameter int H_TOT  = 1667,
    parameter int V_VIS  = 720,
    parameter int V_TOT  = 750,
    parameter int X_BITS = 11,
    parameter int Y_BITS = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [X_BITS-1:0] x,
    input logic [Y_BITS-1:0] y,
    input logic              active,
    input logic [7:0]        red,
    input logic [7:0]        green,
    input logic [7:0]        blue,
    input logic [7:0]        frame
);
    localparam logic [X_BITS-1:0] CX_LAST = X_BITS'(H_TOT - 1);
    localparam logic [Y_BITS-1:0] CY_LAST = Y_BITS'(V_TOT - 1);
    localparam logic [X_BITS-1:0] CX_VL   = X_BITS'(H_VIS - 1);
    localparam logic [Y_BITS-1:0] CY_VL   = Y_BITS'(V_VIS - 1);

    logic at_end;
    assign at_end = active && (x == CX_VL) && (y == CY_VL);

    a_r2_x_step: assert property (@(posedge clk) disable iff (rst)
        (x != CX_LAST) |=> (x == $past(x) + 1'b1));
    a_r2_x_wrap: assert property (@(posedge clk) disable iff (rst)
        (x == CX_LAST) |=> (x == '0));
    a_r3_y_hold: assert property (@(posedge clk) disable iff (rst)
        (x != CX_LAST) |=> $stable(y));
    a_r3_y_step: assert property (@(posedge clk) disable iff (rst)
        (x == CX_LAST && y != CY_LAST) |=> (y == $past(y) + 1'b1));
    a_r3_y_wrap: assert property (@(posedge clk) disable iff (rst)
        (x == CX_LAST && y == CY_LAST) |=> (y == '0));
    a_r8_dark: assert property (@(posedge clk) disable iff (rst)
        !active |-> (red == 8'd0 && green == 8'd0 && blue == 8'd0));
    a_r9_frame_hold: assert property (@(posedge clk) disable iff (rst)
        !at_end |=> $stable(frame));
    a_r9_frame_step: assert property (@(posedge clk) disable iff (rst)
        at_end |=> (frame == $past(frame) + 8'd1));
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (x == '0 && y == '0 && frame == 8'd0));
endmodule

bind tpg_top tpg_checker #(
    .H_VIS(H_VIS), .H_TOT(H_TOT), .V_VIS(V_VIS), .V_TOT(V_TOT),
    .X_BITS(X_BITS), .Y_BITS(Y_BITS)
) u_chk (
    .clk(clk), .rst(rst), .x(x), .y(y), .active(active),
    .red(red), .green(green), .blue(blue), .frame(frame_q)
);

// File: tb/sim_tpg_top.sv
`timescale 1ns/1ps
module sim_tpg_top;
    localparam int H_VIS  = 2;
    localparam int H_TOT  = 32;
    localparam int V_VIS  = 1;
    localparam int V_TOT  = 16;
    localparam int X_BITS = 11;
    localparam int Y_BITS = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [X_BITS-1:0] x;
    logic [Y_BITS-1:0] y;
    logic              active;
    logic [7:0]        red, green, blue;

    int tests = 0;
    int fails = 0;
    bit started = 1'b0;
    bit done = 1'b0;

    // reference model state
    int ex = 0, ey = 0;
    logic [7:0] ef = 8'd0;

    always #2 clk = ~clk;

    tpg_top #(
        .H_VIS(H_VIS), .H_TOT(H_TOT), .V_VIS(V_VIS), .V_TOT(V_TOT),
        .X_BITS(X_BITS), .Y_BITS(Y_BITS)
    ) u0 (
        .clk(clk), .rst(rst), .x(x), .y(y), .active(active),
        .red(red), .green(green), .blue(blue)
    );

    function automatic bit exp_active(int cx, int cy);
        return (cx < H_VIS) && (cy < V_VIS);
    endfunction
    function automatic logic [7:0] exp_red(int cx, logic [7:0] f);
        return 8'(cx) + f;
    endfunction
    function automatic logic [7:0] exp_green(int cy, logic [7:0] f);
        return 8'(cy) + 8'(2 * f);
    endfunction
    function automatic logic [7:0] exp_blue(int cx, int cy);
        return 8'(cx) ^ 8'(cy);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (ex=%0d ey=%0d ef=%0d)",
                     req, act, exp, ex, ey, ef);
        end
    endtask

    // model: advances on each rising edge from the requirements
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            ex <= 0; ey <= 0; ef <= 8'd0;               // R1
        end else begin
            if (exp_active(ex, ey) && ex == H_VIS-1 && ey == V_VIS-1)
                ef <= ef + 8'd1;                        // R9
            if (ex == H_TOT-1) begin
                ex <= 0;                                // R2
                ey <= (ey == V_TOT-1) ? 0 : ey + 1;     // R3
            end else begin
                ex <= ex + 1;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R2 x", int'(x), ex);
            chk("R3 y", int'(y), ey);
            chk("R4 active", int'(active), int'(exp_active(ex, ey)));
            if (exp_active(ex, ey)) begin
                chk("R5 red", int'(red), int'(exp_red(ex, ef)));
                chk("R6 green", int'(green), int'(exp_green(ey, ef)));
                chk("R7 blue", int'(blue), int'(exp_blue(ex, ey)));
            end else begin
                chk("R8 dark", int'({red, green, blue}), 0);
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state, visible before release
        chk("R1 reset x", int'(x), 0);
        chk("R1 reset y", int'(y), 0);
        chk("R1 reset red (frame=0)", int'(red), 0);
        rst = 1'b0;

        // random reset pulses over free running scan
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rst = ($urandom % 400) == 0;
        end
        rst = 1'b0;

        // let the frame count reach a nonzero value
        repeat (5 * H_TOT * V_TOT) @(negedge clk);

        // R1 vs R9 in the same cycle: reset on the last visible pixel
        while (!(ex == H_VIS-1 && ey == V_VIS-1)) @(negedge clk);
        chk("R9 frame nonzero before clash", int'(ef != 8'd0), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset beats frame advance: red at x=0", int'(red), 0);
        chk("R1 reset beats frame advance: green at y=0", int'(green), 0);

        // long run across the 255->0 wrap of the frame count (R9)
        repeat (260 * H_TOT * V_TOT) @(negedge clk);
        chk("R9 frame wrapped to low value", int'(ef < 8'd10), 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule